// File: doc/BRIEF.md
# Polled and Interrupt-Driven Character Port Pair

This block is a small register file that sits on a byte-wide processor bus. It joins a character source (the keyboard) and a character sink (the display) to that bus, so that software can move characters with plain byte loads and stores. Each device has three registers: a data register, a status register and a control register. Each status register carries a ready flag. The flag is set by the device side. It is cleared in hardware as a side effect of a bus read of that status register.

Software can use the block in two ways. It can spin on a status register, testing the keyboard flag with mask 0x02 or the display flag with mask 0x04. Or it can set the per-device enable bit in the control register and wait for the matching interrupt-request output. The keyboard is modelled as a valid strobe carrying a character. The display is modelled as an outgoing one-cycle strobe with a character, plus an incoming completion pulse.

Register offsets on `bus_addr` are:

| Offset | Register |
|---|---|
| 0 | keyboard data |
| 1 | keyboard status |
| 2 | keyboard control |
| 4 | display data |
| 5 | display status |
| 6 | display control |

Every other offset reads as 0.

Top module: `kdp_port`

## Requirements
- R1: Immediately after reset, the block is in this state:
  - `kb_irq`, `dp_irq` and `dp_valid` are 0.
  - Keyboard data (offset 0), keyboard status (offset 1) and both control registers (offsets 2 and 6) read 0x00.
  - The first read of display status (offset 5) returns 0x04, because the display starts out ready.
- R2: A cycle with `kb_valid` high stores `kb_char` into keyboard data (offset 0). From the next cycle on, keyboard status reads with bit 1 set (0x02).
- R3: A bus read of keyboard status returns the current flag and then clears bit 1, so an immediately repeated read returns 0x00. Reading keyboard data leaves both the stored character and the flag unchanged.
- R4: A cycle with `dp_done` high sets display status bit 2 (0x04) from the next cycle on. A bus read of display status returns the flag and then clears it.
- R5: A byte store to display data (offset 4) has three effects in the cycle after the store:
  - `dp_valid` is high for exactly that one cycle.
  - `dp_char` equals the stored byte.
  - Display status bit 2 is cleared.
- R6: When a status read falls in the same cycle as a flag-setting event (`kb_valid` for the keyboard, `dp_done` for the display), the set wins. The read returns the old value, and the flag reads 1 afterwards.
- R7: The keyboard enable is bit 1 of keyboard control (offset 2). The display enable is bit 2 of display control (offset 6). Both are written by stores and read back. All other control bits read 0.
- R8: `kb_irq` is high exactly when the keyboard flag and the keyboard enable are both 1, in the same cycle that the flag becomes visible in status.
- R9: `dp_irq` is high exactly when the display flag and the display enable are both 1, in the same cycle that the flag becomes visible in status.
- R10: When a store to display data and `dp_done` fall in the same cycle, the store wins. The display flag ends at 0 and the strobe is still issued.
- R11: Stores to keyboard data, keyboard status and display status have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Byte load strobe; status side effects take place at the clock edge |
| bus_wr | input | 1 | Byte store strobe |
| bus_wdata | input | 8 | Store data |
| bus_rdata | output | 8 | Load data, combinational from `bus_addr` while `bus_rd` is high, 0 otherwise |
| kb_valid | input | 1 | Keyboard character strobe |
| kb_char | input | 8 | Keyboard character |
| dp_valid | output | 1 | One-cycle strobe sending a character to the display |
| dp_char | output | 8 | Character sent to the display |
| dp_done | input | 1 | Display has finished showing the previous character |
| kb_irq | output | 1 | Keyboard interrupt request, registered |
| dp_irq | output | 1 | Display interrupt request, registered |

## Verification
A ready flag held in the wrong state shows up in two places: on the next status read, and on the interrupt output in the very next cycle. So a lost set, or a clear that comes too early, can be seen one cycle after the event. Collisions between reads, stores and device events are the cases most likely to hide a wrong priority. Those collisions are driven in the same cycle on purpose, and the status register is read back immediately afterwards. A display strobe that is missing or stretched appears on `dp_valid` one cycle after the store.

// File: rtl/kdp_pkg.sv
package kdp_pkg;

    // Register offsets on the bus.
    localparam int OFS_KDATA = 0;
    localparam int OFS_KSTAT = 1;
    localparam int OFS_KCTRL = 2;
    localparam int OFS_DDATA = 4;
    localparam int OFS_DSTAT = 5;
    localparam int OFS_DCTRL = 6;

    // Flag and enable bit positions. Software depends on these.
    localparam int KIN_BIT  = 1;
    localparam int DOUT_BIT = 2;
    localparam int KEN_BIT  = 1;
    localparam int DEN_BIT  = 2;

    // Decoded bus strobes.
    typedef struct packed {
        logic kstat_rd;
        logic kctrl_wr;
        logic ddata_wr;
        logic dstat_rd;
        logic dctrl_wr;
    } strb_t;

endpackage

// File: rtl/kdp_decode.sv
module kdp_decode
    import kdp_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output strb_t             strb
);

    always_comb begin
        strb          = '0;
        strb.kstat_rd = rd && (addr == ADDR_W'(OFS_KSTAT));
        strb.kctrl_wr = wr && (addr == ADDR_W'(OFS_KCTRL));
        strb.ddata_wr = wr && (addr == ADDR_W'(OFS_DDATA));
        strb.dstat_rd = rd && (addr == ADDR_W'(OFS_DSTAT));
        strb.dctrl_wr = wr && (addr == ADDR_W'(OFS_DCTRL));
    end

endmodule

// File: rtl/kdp_kbd_side.sv
module kdp_kbd_side #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [DATA_W-1:0] key_char,
    input  logic              stat_rd,
    input  logic              ctrl_wr,
    input  logic              ctrl_bit,
    output logic [DATA_W-1:0] data_o,
    output logic              flag_o,
    output logic              en_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              flag;
        logic              en;
        logic              irq;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (key_valid) begin
            s_d.data = key_char;
        end
        // A new character beats the clear-on-read.
        if (key_valid) begin
            s_d.flag = 1'b1;
        end else if (stat_rd) begin
            s_d.flag = 1'b0;
        end
        if (ctrl_wr) begin
            s_d.en = ctrl_bit;
        end
        s_d.irq = s_d.flag && s_d.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign data_o = s_q.data;
    assign flag_o = s_q.flag;
    assign en_o   = s_q.en;
    assign irq_o  = s_q.irq;

endmodule

// File: rtl/kdp_disp_side.sv
module kdp_disp_side #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              stat_rd,
    input  logic              ctrl_wr,
    input  logic              ctrl_bit,
    input  logic              done,
    output logic              strobe_o,
    output logic [DATA_W-1:0] char_o,
    output logic              flag_o,
    output logic              en_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              strobe;
        logic              flag;
        logic              en;
        logic              irq;
    } st_t;

    // The display comes out of reset ready.
    localparam st_t RST_ST = '{data: '0, strobe: 1'b0, flag: 1'b1, en: 1'b0, irq: 1'b0};

    st_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.strobe = data_wr;
        if (data_wr) begin
            s_d.data = wdata;
        end
        // A store starts a new character, so it clears the flag even if
        // the previous character completes in the same cycle. A completion
        // beats the clear-on-read.
        if (data_wr) begin
            s_d.flag = 1'b0;
        end else if (done) begin
            s_d.flag = 1'b1;
        end else if (stat_rd) begin
            s_d.flag = 1'b0;
        end
        if (ctrl_wr) begin
            s_d.en = ctrl_bit;
        end
        s_d.irq = s_d.flag && s_d.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= RST_ST;
        end else begin
            s_q <= s_d;
        end
    end

    assign strobe_o = s_q.strobe;
    assign char_o   = s_q.data;
    assign flag_o   = s_q.flag;
    assign en_o     = s_q.en;
    assign irq_o    = s_q.irq;

endmodule

// File: rtl/kdp_port.sv
module kdp_port
    import kdp_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              kb_valid,
    input  logic [DATA_W-1:0] kb_char,
    output logic              dp_valid,
    output logic [DATA_W-1:0] dp_char,
    input  logic              dp_done,
    output logic              kb_irq,
    output logic              dp_irq
);

    strb_t             strb;
    logic [DATA_W-1:0] kdata_w;
    logic              kin_w;
    logic              ken_w;
    logic              dout_w;
    logic              den_w;

    kdp_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .strb (strb)
    );

    kdp_kbd_side #(.DATA_W(DATA_W)) u_kbd (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (kb_valid),
        .key_char  (kb_char),
        .stat_rd   (strb.kstat_rd),
        .ctrl_wr   (strb.kctrl_wr),
        .ctrl_bit  (bus_wdata[KEN_BIT]),
        .data_o    (kdata_w),
        .flag_o    (kin_w),
        .en_o      (ken_w),
        .irq_o     (kb_irq)
    );

    kdp_disp_side #(.DATA_W(DATA_W)) u_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_wr  (strb.ddata_wr),
        .wdata    (bus_wdata),
        .stat_rd  (strb.dstat_rd),
        .ctrl_wr  (strb.dctrl_wr),
        .ctrl_bit (bus_wdata[DEN_BIT]),
        .done     (dp_done),
        .strobe_o (dp_valid),
        .char_o   (dp_char),
        .flag_o   (dout_w),
        .en_o     (den_w),
        .irq_o    (dp_irq)
    );

    // Read data reflects the register state before this cycle's side effects.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_W'(OFS_KDATA)) begin
                bus_rdata = kdata_w;
            end else if (bus_addr == ADDR_W'(OFS_KSTAT)) begin
                bus_rdata[KIN_BIT] = kin_w;
            end else if (bus_addr == ADDR_W'(OFS_KCTRL)) begin
                bus_rdata[KEN_BIT] = ken_w;
            end else if (bus_addr == ADDR_W'(OFS_DSTAT)) begin
                bus_rdata[DOUT_BIT] = dout_w;
            end else if (bus_addr == ADDR_W'(OFS_DCTRL)) begin
                bus_rdata[DEN_BIT] = den_w;
            end
        end
    end

endmodule

// File: rtl/kdp_checker.sv
module kdp_checker
    import kdp_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              kb_valid,
    input logic              dp_valid,
    input logic [DATA_W-1:0] dp_char,
    input logic              dp_done,
    input logic              kb_irq,
    input logic              dp_irq,
    input logic              kin,
    input logic              ken,
    input logic              dout,
    input logic              den
);

    logic ks_rd;
    logic dd_wr;

    assign ks_rd = bus_rd && (bus_addr == ADDR_W'(OFS_KSTAT));
    assign dd_wr = bus_wr && (bus_addr == ADDR_W'(OFS_DDATA));

    AST_KEY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        kb_valid |=> kin); // R2

    AST_KSTAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_rd && !kb_valid) |=> !kin); // R3

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_done && !dd_wr) |=> dout); // R4

    AST_STORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        dd_wr |=> (dp_valid && !dout && dp_char == $past(bus_wdata))); // R5

    AST_STROBE_ONLY_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        dp_valid |-> $past(dd_wr)); // R5

    AST_KIRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        kb_irq == (kin && ken)); // R8

    AST_DIRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        dp_irq == (dout && den)); // R9

endmodule

bind kdp_port kdp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .kb_valid  (kb_valid),
    .dp_valid  (dp_valid),
    .dp_char   (dp_char),
    .dp_done   (dp_done),
    .kb_irq    (kb_irq),
    .dp_irq    (dp_irq),
    .kin       (kin_w),
    .ken       (ken_w),
    .dout      (dout_w),
    .den       (den_w)
);

// File: tb/kdp_port_bench.sv
module kdp_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       kb_valid = 1'b0;
    logic [7:0] kb_char = '0;
    logic       dp_valid;
    logic [7:0] dp_char;
    logic       dp_done = 1'b0;
    logic       kb_irq;
    logic       dp_irq;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    kdp_port u_kdp_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .kb_valid  (kb_valid),
        .kb_char   (kb_char),
        .dp_valid  (dp_valid),
        .dp_char   (dp_char),
        .dp_done   (dp_done),
        .kb_irq    (kb_irq),
        .dp_irq    (dp_irq)
    );

    // Vector ops: 0 = read and compare, 1 = store, 2 = key arrives, 3 = display done.
    typedef struct packed {
        logic [1:0] op;
        logic [2:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 3'd0, 8'h41, 8'h00, 4'd2},   // R2 key 'A'
        '{2'd0, 3'd0, 8'h00, 8'h41, 4'd2},   // R2 data latched
        '{2'd0, 3'd1, 8'h00, 8'h02, 4'd2},   // R2 flag set
        '{2'd0, 3'd1, 8'h00, 8'h00, 4'd3},   // R3 cleared by read
        '{2'd0, 3'd0, 8'h00, 8'h41, 4'd3},   // R3 data kept
        '{2'd0, 3'd5, 8'h00, 8'h04, 4'd1},   // R1 display ready after reset
        '{2'd0, 3'd5, 8'h00, 8'h00, 4'd4},   // R4 cleared by read
        '{2'd3, 3'd0, 8'h00, 8'h00, 4'd4},   // R4 done pulse
        '{2'd0, 3'd5, 8'h00, 8'h04, 4'd4},   // R4 set
        '{2'd0, 3'd5, 8'h00, 8'h00, 4'd4},   // R4 cleared again
        '{2'd1, 3'd2, 8'hFF, 8'h00, 4'd7},   // R7 keyboard enable
        '{2'd0, 3'd2, 8'h00, 8'h02, 4'd7},   // R7 only bit 1 kept
        '{2'd1, 3'd6, 8'hFF, 8'h00, 4'd7},   // R7 display enable
        '{2'd0, 3'd6, 8'h00, 8'h04, 4'd7},   // R7 only bit 2 kept
        '{2'd1, 3'd1, 8'hFF, 8'h00, 4'd11},  // R11 store to kbd status
        '{2'd0, 3'd1, 8'h00, 8'h00, 4'd11},  // R11 unchanged
        '{2'd1, 3'd0, 8'h55, 8'h00, 4'd11},  // R11 store to kbd data
        '{2'd0, 3'd0, 8'h00, 8'h41, 4'd11},  // R11 unchanged
        '{2'd1, 3'd5, 8'hFF, 8'h00, 4'd11},  // R11 store to disp status
        '{2'd0, 3'd5, 8'h00, 8'h00, 4'd11},  // R11 unchanged
        '{2'd1, 3'd2, 8'h00, 8'h00, 4'd7},   // R7 keyboard enable off
        '{2'd0, 3'd2, 8'h00, 8'h00, 4'd7}    // R7 reads back 0
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic key(input logic [7:0] c);
        @(negedge clk);
        kb_valid = 1'b1;
        kb_char  = c;
        @(negedge clk);
        kb_valid = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        dp_done = 1'b1;
        @(negedge clk);
        dp_done = 1'b0;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state; display status is not read here, the table does it
        @(negedge clk);
        chk("R1 kb_irq", {7'd0, kb_irq}, 8'h00);
        chk("R1 dp_irq", {7'd0, dp_irq}, 8'h00);
        chk("R1 dp_valid", {7'd0, dp_valid}, 8'h00);
        bus_read(3'd0, r); chk("R1 kbd data", r, 8'h00);
        bus_read(3'd1, r); chk("R1 kbd status", r, 8'h00);
        bus_read(3'd2, r); chk("R1 kbd ctrl", r, 8'h00);
        bus_read(3'd6, r); chk("R1 disp ctrl", r, 8'h00);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: begin
                    bus_read(VEC[i].addr, r);
                    chk($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].exp);
                end
                2'd1: bus_write(VEC[i].addr, VEC[i].data);
                2'd2: key(VEC[i].data);
                default: done_pulse();
            endcase
        end

        // R8 keyboard interrupt follows flag and enable
        bus_write(3'd2, 8'h02);
        key(8'h61);
        chk("R8 irq with flag", {7'd0, kb_irq}, 8'h01);
        bus_read(3'd1, r); chk("R8 status", r, 8'h02);
        chk("R8 irq after read", {7'd0, kb_irq}, 8'h00);
        bus_write(3'd2, 8'h00);
        key(8'h62);
        chk("R8 irq disabled", {7'd0, kb_irq}, 8'h00);
        bus_read(3'd1, r); chk("R8 flag still set", r, 8'h02);

        // R9 display interrupt; enable still on, flag currently clear
        chk("R9 irq idle", {7'd0, dp_irq}, 8'h00);
        done_pulse();
        chk("R9 irq on done", {7'd0, dp_irq}, 8'h01);

        // R5 store sends one strobe and clears the flag
        @(negedge clk);
        bus_addr  = 3'd4;
        bus_wdata = 8'h4B;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R5 strobe", {7'd0, dp_valid}, 8'h01);
        chk("R5 char", dp_char, 8'h4B);
        chk("R5 irq dropped", {7'd0, dp_irq}, 8'h00);
        @(negedge clk);
        chk("R5 strobe one cycle", {7'd0, dp_valid}, 8'h00);
        bus_read(3'd5, r); chk("R5 flag cleared", r, 8'h00);

        // R6 set beats read, keyboard
        @(negedge clk);
        bus_addr = 3'd1;
        bus_rd   = 1'b1;
        kb_valid = 1'b1;
        kb_char  = 8'h33;
        #1 r = bus_rdata;
        chk("R6 kbd old value", r, 8'h00);
        @(negedge clk);
        bus_rd   = 1'b0;
        kb_valid = 1'b0;
        bus_read(3'd1, r); chk("R6 kbd flag kept", r, 8'h02);
        bus_read(3'd0, r); chk("R6 kbd char", r, 8'h33);

        // R6 set beats read, display
        @(negedge clk);
        bus_addr = 3'd5;
        bus_rd   = 1'b1;
        dp_done  = 1'b1;
        #1 r = bus_rdata;
        chk("R6 disp old value", r, 8'h00);
        @(negedge clk);
        bus_rd  = 1'b0;
        dp_done = 1'b0;
        bus_read(3'd5, r); chk("R6 disp flag kept", r, 8'h04);

        // R10 store beats done
        @(negedge clk);
        bus_addr  = 3'd4;
        bus_wdata = 8'h7E;
        bus_wr    = 1'b1;
        dp_done   = 1'b1;
        @(negedge clk);
        bus_wr  = 1'b0;
        dp_done = 1'b0;
        chk("R10 strobe", {7'd0, dp_valid}, 8'h01);
        chk("R10 char", dp_char, 8'h7E);
        bus_read(3'd5, r); chk("R10 flag clear", r, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule